// File: doc/BRIEF.md
# Lockable Security Control Register

This block is a small register slice on a 32-bit word-access bus. It keeps a control word whose fields steer debug, security and encryption features elsewhere on the chip. It also keeps a sticky lock register. Each lock bit freezes one group of control fields against later writes, and only reset clears a lock bit. A third location takes an unlock key. The correct key grants access to the register space and forces the protected-path bit and the 3-bit encryption-enable field to ones. Any other value revokes access and clears those same bits.

The current control word is driven out continuously, together with an access-enabled flag and a flag that reports when the 3-bit encryption-enable field is neither all-zeros nor all-ones. Software reads through a registered read port. The byte offsets are 0x00 for control, 0x04 for lock and 0x08 for the key, and all three are parameters.

Top module: `lockable_ctrl_reg`

## Requirements
- R1: After reset the control word is 0x0C006000 (bits 27, 26, 14 and 13 set), all lock bits are clear, access is enabled, the inconsistency flag is low and rdata_o is zero.
- R2: A write to the lock offset ORs wdata_i[4:0] into the 5-bit lock state, so a lock bit stays set until reset. A read of the lock offset returns the lock state in bits 4:0, with zeros above.
- R3: On a control write, the bits covered by each set lock bit keep their old value and every other bit takes the written value. The groups are: lock bit 0 covers control bits 6:0, lock bit 1 covers bit 7, lock bit 2 covers bit 8, lock bit 3 covers bits 11:9 and lock bit 4 covers bit 12.
- R4: Control bit 31 ignores writes and always reads as zero.
- R5: Writing 0x757BDF0D to the key offset sets control bit 27 and bits 11:9, whatever the lock state, and enables access. Control and lock writes are dropped while access is disabled, so no other write can land in the same cycle.
- R6: Writing any other value to the key offset clears control bit 27 and bits 11:9, whatever the lock state, and disables access.
- R7: While access is disabled, every read returns zero and writes to the control and lock offsets are dropped. Key writes are still accepted.
- R8: A write whose byte strobes be_i are not 4'hF has no effect on any register, including the key.
- R9: aes_mix_o is high exactly when control bits 11:9 hold a value other than 3'b000 or 3'b111.
- R10: A read request loads rdata_o at the next clock edge. rdata_o then holds that value until the next read. Reads of the key offset or of an unmapped offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address of the access |
| be_i | input | 4 | Byte strobes; writes need all four |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ctrl_o | output | 32 | Current control word |
| access_en_o | output | 1 | Register access granted |
| aes_mix_o | output | 1 | Encryption-enable field is inconsistent |

## Verification
Every write takes effect at the clock edge that samples it. ctrl_o, access_en_o and aes_mix_o therefore show the new value in the first cycle after the request, and a read result appears on rdata_o in that same following cycle. The bench drives requests on the falling edge and updates a behavioural model on the rising edge. It compares all outputs against the model on each falling edge, half a cycle after the update, and compares directed literal values at those same points. Lock stickiness, frozen groups, key handling and the disabled-access behaviour are each exercised in their own phase of the sequence.

// File: rtl/lockable_ctrl_pkg.sv
package lockable_ctrl_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned NUM_LOCK = 5;
  localparam int unsigned BE_W     = DATA_W / 8;

  localparam int unsigned PR_BIT   = 27;
  localparam int unsigned FRC_BIT  = 31;
  localparam int unsigned AES_LSB  = 9;
  localparam int unsigned AES_W    = 3;

  localparam logic [DATA_W-1:0] CTRL_RST = 32'h0C00_6000;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h757B_DF0D;
  localparam logic [DATA_W-1:0] AES_MASK = ((DATA_W'(1) << AES_W) - 1) << AES_LSB;
  localparam logic [DATA_W-1:0] KEY_BITS = (DATA_W'(1) << PR_BIT) | AES_MASK;
  localparam logic [DATA_W-1:0] FRC_MASK = DATA_W'(1) << FRC_BIT;

  // control bits frozen by each lock bit
  function automatic logic [DATA_W-1:0] grp_mask(int unsigned idx);
    case (idx)
      0:       grp_mask = 32'h0000_007F;
      1:       grp_mask = 32'h0000_0080;
      2:       grp_mask = 32'h0000_0100;
      3:       grp_mask = AES_MASK;
      4:       grp_mask = 32'h0000_1000;
      default: grp_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/lcr_lock_bits.sv
module lcr_lock_bits
  import lockable_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [NUM_LOCK-1:0] wdata_i,
  output logic [NUM_LOCK-1:0] lock_o
);
  logic [NUM_LOCK-1:0] lock_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lock_q <= '0;
    else if (wr_i) lock_q <= lock_q | wdata_i;
  end

  assign lock_o = lock_q;
endmodule

// File: rtl/lcr_key_gate.sv
module lcr_key_gate
  import lockable_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [DATA_W-1:0] key_data_i,
  output logic              key_ok_o,
  output logic              key_bad_o,
  output logic              access_en_o
);
  logic match;
  logic en_q;

  assign match     = (key_data_i == UNLOCK_KEY);
  assign key_ok_o  = key_wr_i & match;
  assign key_bad_o = key_wr_i & ~match;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_q <= 1'b1;
    else if (key_wr_i)  en_q <= match;
  end

  assign access_en_o = en_q;
endmodule

// File: rtl/lcr_ctrl_word.sv
module lcr_ctrl_word
  import lockable_ctrl_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [NUM_LOCK-1:0] lock_i,
  input  logic                key_ok_i,
  input  logic                key_bad_i,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic                aes_mix_o
);
  logic [DATA_W-1:0] grp [NUM_LOCK];
  logic [DATA_W-1:0] frozen;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] wr_val;
  logic [AES_W-1:0]  aes_f;

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_grp
    assign grp[g] = lock_i[g] ? grp_mask(g) : '0;
  end

  always_comb begin
    frozen = '0;
    for (int i = 0; i < NUM_LOCK; i++) frozen = frozen | grp[i];
  end

  assign wr_val = ((wdata_i & ~frozen) | (ctrl_q & frozen)) & ~FRC_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         ctrl_q <= CTRL_RST;
    else if (wr_i)       ctrl_q <= wr_val;
    else if (key_ok_i)   ctrl_q <= ctrl_q | KEY_BITS;
    else if (key_bad_i)  ctrl_q <= ctrl_q & ~KEY_BITS;
  end

  assign aes_f     = ctrl_q[AES_LSB +: AES_W];
  assign aes_mix_o = (|aes_f) & ~(&aes_f);
  assign ctrl_o    = ctrl_q;
endmodule

// File: rtl/lockable_ctrl_reg.sv
module lockable_ctrl_reg
  import lockable_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned CTRL_OFS = 'h00,
  parameter int unsigned LOCK_OFS = 'h04,
  parameter int unsigned KEY_OFS  = 'h08
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] ctrl_o,
  output logic              access_en_o,
  output logic              aes_mix_o
);
  logic sel_ctrl, sel_lock, sel_key;
  logic wr_ok, rd_req;
  logic ctrl_wr, lock_wr, key_wr;
  logic key_ok, key_bad, acc_en;
  logic [NUM_LOCK-1:0] lock_q;
  logic [DATA_W-1:0]   ctrl_q;
  logic [DATA_W-1:0]   rd_mux;
  logic [DATA_W-1:0]   rdata_q;

  assign sel_ctrl = (addr_i == ADDR_W'(CTRL_OFS));
  assign sel_lock = (addr_i == ADDR_W'(LOCK_OFS));
  assign sel_key  = (addr_i == ADDR_W'(KEY_OFS));

  assign wr_ok   = req_i & we_i & (&be_i);
  assign rd_req  = req_i & ~we_i;
  assign ctrl_wr = wr_ok & acc_en & sel_ctrl;
  assign lock_wr = wr_ok & acc_en & sel_lock;
  assign key_wr  = wr_ok & sel_key;  // key path bypasses the access gate

  lcr_lock_bits u_lock (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (lock_wr),
    .wdata_i (wdata_i[NUM_LOCK-1:0]),
    .lock_o  (lock_q)
  );

  lcr_key_gate u_key (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .key_wr_i    (key_wr),
    .key_data_i  (wdata_i),
    .key_ok_o    (key_ok),
    .key_bad_o   (key_bad),
    .access_en_o (acc_en)
  );

  lcr_ctrl_word u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (ctrl_wr),
    .wdata_i   (wdata_i),
    .lock_i    (lock_q),
    .key_ok_i  (key_ok),
    .key_bad_i (key_bad),
    .ctrl_o    (ctrl_q),
    .aes_mix_o (aes_mix_o)
  );

  always_comb begin
    rd_mux = '0;
    if (acc_en) begin
      if (sel_ctrl)      rd_mux = ctrl_q;
      else if (sel_lock) rd_mux = DATA_W'(lock_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end

  assign rdata_o     = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign access_en_o = acc_en;
endmodule

// File: rtl/lockable_ctrl_reg_chk.sv
module lockable_ctrl_reg_chk
  import lockable_ctrl_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic                we_i,
  input logic [DATA_W-1:0]   rdata_o,
  input logic [DATA_W-1:0]   ctrl_o,
  input logic                access_en_o,
  input logic [NUM_LOCK-1:0] lock_q
);
  assert_lock_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  assert_dbg_group_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q[0] |=> (ctrl_o[6:0] == $past(ctrl_o[6:0])));

  assert_force_bit_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_o[FRC_BIT] == 1'b0);

  assert_unlock_sets_bits_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(access_en_o) |-> (ctrl_o[PR_BIT] && (ctrl_o[AES_LSB +: AES_W] == '1)));

  assert_revoke_clears_bits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(access_en_o) |-> (!ctrl_o[PR_BIT] && (ctrl_o[AES_LSB +: AES_W] == '0)));

  assert_locked_ctrl_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!access_en_o) |=> (!access_en_o ? $stable(ctrl_o) : 1'b1));

  assert_locked_read_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !access_en_o) |=> (rdata_o == '0));
endmodule

bind lockable_ctrl_reg lockable_ctrl_reg_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .rdata_o     (rdata_o),
  .ctrl_o      (ctrl_o),
  .access_en_o (access_en_o),
  .lock_q      (lock_q)
);

// File: tb/lockable_ctrl_reg_bench.sv
`timescale 1ns/1ps
module lockable_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, ctrl;
  logic        acc_en, aes_mix;

  int n_chk = 0, n_fail = 0;
  bit done = 0, live = 0;

  // behavioural reference
  logic [31:0] m_ctrl, m_rdata;
  logic [4:0]  m_lock;
  logic        m_en;
  logic [31:0] gmask [5];

  always #2.5 clk = ~clk;

  lockable_ctrl_reg u_lockable_ctrl_reg (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .ctrl_o(ctrl),
    .access_en_o(acc_en), .aes_mix_o(aes_mix)
  );

  initial begin
    gmask[0] = 32'h7F; gmask[1] = 32'h80; gmask[2] = 32'h100;
    gmask[3] = 32'hE00; gmask[4] = 32'h1000;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= 32'h0C006000; m_lock <= '0; m_en <= 1'b1; m_rdata <= '0;
    end else if (req) begin
      if (!we) begin
        if (!m_en)              m_rdata <= 0;
        else if (addr == 8'h00) m_rdata <= m_ctrl;
        else if (addr == 8'h04) m_rdata <= {27'd0, m_lock};
        else                    m_rdata <= 0;
      end else if (be == 4'hF) begin
        if (addr == 8'h08) begin
          if (wdata == 32'h757BDF0D) begin
            m_en <= 1'b1; m_ctrl <= m_ctrl | 32'h08000E00;
          end else begin
            m_en <= 1'b0; m_ctrl <= m_ctrl & ~32'h08000E00;
          end
        end else if (m_en && addr == 8'h04) begin
          m_lock <= m_lock | wdata[4:0];
        end else if (m_en && addr == 8'h00) begin
          logic [31:0] keep;
          keep = 0;
          for (int k = 0; k < 5; k++) if (m_lock[k]) keep = keep | gmask[k];
          m_ctrl <= ((wdata & ~keep) | (m_ctrl & keep)) & 32'h7FFFFFFF;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  // per-cycle compare against the model
  always @(negedge clk) begin
    if (live && !done) begin
      chk(ctrl === m_ctrl, "R3 ctrl", ctrl, m_ctrl);
      chk(acc_en === m_en, "R7 access", {31'd0, acc_en}, {31'd0, m_en});
      chk(rdata === m_rdata, "R10 rdata", rdata, m_rdata);
      chk(aes_mix === ((m_ctrl[11:9] != 3'b000) && (m_ctrl[11:9] != 3'b111)),
          "R9 aes_mix", {31'd0, aes_mix}, {31'd0, ((m_ctrl[11:9] != 0) && (m_ctrl[11:9] != 7))});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b = 4'hF);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d; be = b;
    @(negedge clk); req = 0; we = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    @(negedge clk); req = 1; we = 0; addr = a; be = 4'hF;
    @(negedge clk); req = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #20000;
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    live = 1;
    // R1 reset state
    chk(ctrl === 32'h0C006000, "R1 ctrl", ctrl, 32'h0C006000);
    chk(acc_en === 1'b1, "R1 access", {31'd0, acc_en}, 32'd1);
    chk(aes_mix === 1'b0, "R1 aes_mix", {31'd0, aes_mix}, 32'd0);
    chk(rdata === 32'd0, "R1 rdata", rdata, 32'd0);
    rd(8'h04);
    chk(rdata === 32'd0, "R1 lock", rdata, 32'd0);
    rd(8'h00);
    chk(rdata === 32'h0C006000, "R10 read ctrl", rdata, 32'h0C006000);
    // R4 force bit
    wr(8'h00, 32'hFFFFFFFF);
    chk(ctrl === 32'h7FFFFFFF, "R4 bit31", ctrl, 32'h7FFFFFFF);
    // R9 inconsistent field
    wr(8'h00, 32'h00000A00);
    chk(aes_mix === 1'b1, "R9 mix high", {31'd0, aes_mix}, 32'd1);
    wr(8'h00, 32'hFFFFFFFF);
    chk(aes_mix === 1'b0, "R9 mix low", {31'd0, aes_mix}, 32'd0);
    // R2 sticky lock
    wr(8'h04, 32'h1);
    wr(8'h04, 32'h4);
    rd(8'h04);
    chk(rdata === 32'h5, "R2 lock or", rdata, 32'h5);
    wr(8'h04, 32'hFFFFFFE0);
    rd(8'h04);
    chk(rdata === 32'h5, "R2 reserved", rdata, 32'h5);
    // R3 frozen groups
    wr(8'h00, 32'h0);
    chk(ctrl === 32'h0000017F, "R3 freeze", ctrl, 32'h0000017F);
    // R8 partial strobe
    wr(8'h00, 32'hFFFFFFFF, 4'h3);
    chk(ctrl === 32'h0000017F, "R8 ctrl strobe", ctrl, 32'h0000017F);
    wr(8'h08, 32'h0, 4'h7);
    chk(acc_en === 1'b1, "R8 key strobe", {31'd0, acc_en}, 32'd1);
    // R6 bad key
    wr(8'h00, 32'h08000E00);
    wr(8'h08, 32'h12345678);
    chk(acc_en === 1'b0, "R6 revoke", {31'd0, acc_en}, 32'd0);
    chk(ctrl === 32'h0000017F, "R6 cleared", ctrl, 32'h0000017F);
    // R7 disabled
    rd(8'h00);
    chk(rdata === 32'd0, "R7 read zero", rdata, 32'd0);
    wr(8'h00, 32'h00000E80);
    chk(ctrl === 32'h0000017F, "R7 ctrl drop", ctrl, 32'h0000017F);
    wr(8'h04, 32'h10);
    // R5 good key
    wr(8'h08, 32'h757BDF0D);
    chk(acc_en === 1'b1, "R5 enable", {31'd0, acc_en}, 32'd1);
    chk(ctrl === 32'h08000F7F, "R5 set bits", ctrl, 32'h08000F7F);
    rd(8'h04);
    chk(rdata === 32'h5, "R7 lock drop", rdata, 32'h5);
    // R3 freeze of field 11:9, then key overrides lock
    wr(8'h04, 32'h8);
    wr(8'h00, 32'h00000200);
    chk(ctrl === 32'h00000F7F, "R3 aes lock", ctrl, 32'h00000F7F);
    wr(8'h08, 32'h0);
    chk(ctrl === 32'h0000017F, "R6 over lock", ctrl, 32'h0000017F);
    wr(8'h08, 32'h757BDF0D);
    // R10 unmapped and key reads, hold
    rd(8'h08);
    chk(rdata === 32'd0, "R10 key read", rdata, 32'd0);
    rd(8'h00);
    rd(8'h10);
    chk(rdata === 32'd0, "R10 unmapped", rdata, 32'd0);
    rd(8'h00);
    wr(8'h04, 32'h10);
    chk(rdata === 32'h08000F7F, "R10 hold", rdata, 32'h08000F7F);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule